// File: doc/BRIEF.md
# User-Level Event Counter Bank

This block keeps three free-running 64-bit event counters that user code may read but never write. The first counts core clock cycles. The second counts ticks of a real-time reference, and the third counts retired instructions. Each counter has its own increment source. The tick strobe and the retire pulse arrive as single-bit inputs that are already in the core clock domain.

The counters are read through a CSR-style port. A 12-bit address picks the counter, and in a narrow-datapath build it also picks the half. The read data and an illegal-access flag come back combinationally in the same cycle. A narrow build exposes each counter as a low word and a high word. A build whose datapath is as wide as the counter returns the whole value from the low address and rejects the high addresses.

A lean build keeps only the low half of each counter in flops. In every build, each counter raises a one-cycle pulse when its low half wraps, so that software can keep the upper half itself.

Top module: `perf_counter_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all counters clear to zero and `lo_wrap_o` clears to 3'b000. Reads after that edge return zero.
- R2: The cycle counter grows by exactly one at every rising edge after reset is released.
- R3: The time counter grows by one at an edge only when `rt_tick_i` is high before that edge. Otherwise it holds.
- R4: The instret counter grows by one at an edge only when `retire_i` is high before that edge. Otherwise it holds.
- R5: Address 12'hC00 returns bits DATA_W-1:0 of the cycle counter, 12'hC01 those of the time counter, and 12'hC02 those of the instret counter. `csr_illegal_o` is 0 for these addresses.
- R6: When DATA_W < CNT_W, addresses 12'hC80, 12'hC81 and 12'hC82 return bits CNT_W-1:DATA_W of the cycle, time and instret counters, with `csr_illegal_o` 0.
- R7: When DATA_W == CNT_W, addresses 12'hC00 to 12'hC02 return the full counter. Addresses 12'hC80 to 12'hC82 are illegal in this build.
- R8: Any address not made legal by R5 to R7 returns all-zero data with `csr_illegal_o` = 1.
- R9: Bit 0 (cycle), bit 1 (time) or bit 2 (instret) of `lo_wrap_o` is high for exactly the one cycle in which that counter's low half (bits CNT_W/2-1:0) first reads zero after being all-ones. At the same edge the upper half grows by one.
- R10: When KEEP_HIGH = 0, the upper half of every counter reads as zero. The low halves and the wrap pulses behave as in R2 to R4 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rt_tick_i | input | 1 | One-cycle real-time tick strobe, synchronous to clk |
| retire_i | input | 1 | One-cycle pulse for each retired instruction |
| csr_addr_i | input | 12 | Read address |
| csr_rdata_o | output | DATA_W | Selected counter word, zero when illegal |
| csr_illegal_o | output | 1 | Address does not name a readable word |
| lo_wrap_o | output | 3 | Low-half wrap pulses: bit 0 cycle, bit 1 time, bit 2 instret |

## Verification
The hardest event to reach from the ports is the low-half wrap and its carry into the upper half. At full width it needs 2^32 increments. The bench therefore uses 16-bit counters with an 8-bit datapath, so the cycle counter wraps every 256 clocks. It holds both strobes high for long stretches so the time and instret counters also wrap several times. Stretches with both strobes low, and stretches with random strobes, come before and after those runs.

Three instances run in parallel: split, full-width and lean. After every edge, all three are swept through the six legal addresses and a set of illegal ones. A reset in the middle of the run checks that every count and every pulse clears.

// File: rtl/pcb_pkg.sv
// Shared types and constants for the user-level event counter bank.
// Assumes a 12-bit CSR address space. Counter indices double as the low two address bits.
package pcb_pkg;
    localparam int NUM_CTR = 3;
    localparam logic [11:0] ADDR_LO_BASE = 12'hC00;
    localparam logic [11:0] ADDR_HI_BASE = 12'hC80;

    typedef enum logic [1:0] {
        CTR_CYCLE   = 2'd0,
        CTR_TIME    = 2'd1,
        CTR_INSTRET = 2'd2
    } ctr_sel_e;
endpackage

// File: rtl/pcb_counter.sv
// One event counter split into a low and an optional high half.
// Raises wrap_o for one cycle after the low half rolls over from all-ones.
// Assumes an even CNT_W of at least 4. With KEEP_HIGH = 0 the upper half reads as zero.
module pcb_counter #(
    parameter int CNT_W     = 64,
    parameter bit KEEP_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] value_o,
    output logic             wrap_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] low_q;
    logic              wrap_q;
    logic              low_full;

    assign low_full = &low_q;
    assign wrap_o   = wrap_q;

    // Low half: step on each increment and note the rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= inc_i && low_full;
            if (inc_i) begin
                low_q <= low_q + 1'b1;
            end
        end
    end

    generate
        if (KEEP_HIGH) begin : g_high
            logic [HALF_W-1:0] high_q;

            // High half: take the carry out of the low half.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    high_q <= '0;
                end else if (inc_i && low_full) begin
                    high_q <= high_q + 1'b1;
                end
            end

            assign value_o = {high_q, low_q};

            // R9: the carry reaches the upper half in the same edge as the wrap.
            assert_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_i && low_full) |=> (high_q == $past(high_q) + 1'b1));
        end else begin : g_lean
            assign value_o = {{HALF_W{1'b0}}, low_q};
        end
    endgenerate

    // R2 (R3 and R4 through the source tied to inc_i): one step per increment.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (low_q == $past(low_q) + 1'b1));

    // Without an increment the count holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(value_o));

    // R9: the wrap pulse lasts one cycle and sees a zero low half.
    assert_wrap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (low_q == '0) ##1 !wrap_o);
endmodule

// File: rtl/pcb_csr_decode.sv
// Maps a CSR address to a counter index and a half, and flags unknown addresses.
// High-half addresses are legal only when the datapath is narrower than the counter.
module pcb_csr_decode
    import pcb_pkg::*;
#(
    parameter bit HAS_HI = 1'b1
) (
    input  logic [11:0] addr_i,
    output ctr_sel_e    sel_o,
    output logic        hi_o,
    output logic        legal_o
);
    logic lo_hit;
    logic hi_hit;

    // Range match for the two blocks of three addresses.
    always_comb begin
        lo_hit = (addr_i >= ADDR_LO_BASE) && (addr_i < ADDR_LO_BASE + 12'd3);
        hi_hit = HAS_HI && (addr_i >= ADDR_HI_BASE) && (addr_i < ADDR_HI_BASE + 12'd3);
    end

    // Select outputs; the counter index is the low two address bits.
    always_comb begin
        legal_o = lo_hit || hi_hit;
        hi_o    = hi_hit;
        sel_o   = legal_o ? ctr_sel_e'(addr_i[1:0]) : CTR_CYCLE;
    end

    // R7: no high-half access is ever decoded in a full-width build.
    always_comb begin
        if (!HAS_HI) begin
            assert_no_hi_R7: assert (!hi_o);
        end
    end
endmodule

// File: rtl/pcb_read_mux.sv
// Picks one word out of the counter bank for the read port. Returns zero when illegal.
// Assumes CNT_W is DATA_W or twice DATA_W.
module pcb_read_mux
    import pcb_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic [NUM_CTR-1:0][CNT_W-1:0] values_i,
    input  ctr_sel_e                      sel_i,
    input  logic                          hi_i,
    input  logic                          legal_i,
    output logic [DATA_W-1:0]             rdata_o
);
    logic [CNT_W-1:0] picked;

    // Word select by counter index, then by half.
    always_comb begin
        picked = (int'(sel_i) < NUM_CTR) ? values_i[sel_i] : '0;
        if (!legal_i) begin
            rdata_o = '0;
        end else if (hi_i) begin
            rdata_o = picked[CNT_W-1 -: DATA_W];
        end else begin
            rdata_o = picked[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/perf_counter_bank.sv
// User-readable bank of cycle, time and instret counters with a CSR read port.
// Assumes rt_tick_i and retire_i are single-cycle strobes in the clk domain,
// and DATA_W is CNT_W or CNT_W / 2.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int DATA_W    = 32,
    parameter bit KEEP_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rt_tick_i,
    input  logic              retire_i,
    input  logic [11:0]       csr_addr_i,
    output logic [DATA_W-1:0] csr_rdata_o,
    output logic              csr_illegal_o,
    output logic [2:0]        lo_wrap_o
);
    localparam bit HAS_HI = (DATA_W < CNT_W);

    logic [NUM_CTR-1:0]            inc_src;
    logic [NUM_CTR-1:0][CNT_W-1:0] values;
    logic [NUM_CTR-1:0]            wraps;
    ctr_sel_e                      sel;
    logic                          hi;
    logic                          legal;

    // Increment sources, in counter-index order.
    always_comb begin
        inc_src[CTR_CYCLE]   = 1'b1;
        inc_src[CTR_TIME]    = rt_tick_i;
        inc_src[CTR_INSTRET] = retire_i;
    end

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            pcb_counter #(
                .CNT_W     (CNT_W),
                .KEEP_HIGH (KEEP_HIGH)
            ) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc_i   (inc_src[i]),
                .value_o (values[i]),
                .wrap_o  (wraps[i])
            );
        end
    endgenerate

    pcb_csr_decode #(
        .HAS_HI (HAS_HI)
    ) u_dec (
        .addr_i  (csr_addr_i),
        .sel_o   (sel),
        .hi_o    (hi),
        .legal_o (legal)
    );

    pcb_read_mux #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .values_i (values),
        .sel_i    (sel),
        .hi_i     (hi),
        .legal_i  (legal),
        .rdata_o  (csr_rdata_o)
    );

    assign csr_illegal_o = !legal;
    assign lo_wrap_o     = wraps;

    // R8: an illegal access never leaks counter data.
    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal_o |-> (csr_rdata_o == '0));

    // R1: the edge after reset leaves no wrap pulse pending.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (lo_wrap_o == 3'b000));

    // R2: the cycle counter never skips an edge, so its wrap never repeats back to back.
    assert_cycle_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wrap_o[0] |=> !lo_wrap_o[0]);
endmodule

// File: tb/perf_counter_bank_tb.sv
// Sweeps three small builds (split, full-width, lean) against an arithmetic model.
module perf_counter_bank_tb;
    localparam int CLK_P = 40;
    localparam int CW    = 16;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          ret = 1'b0;
    logic [11:0]   addr = 12'h000;
    logic [DW-1:0] rd_s, rd_l;
    logic [CW-1:0] rd_w;
    logic          il_s, il_w, il_l;
    logic [2:0]    wr_s, wr_w, wr_l;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [CW-1:0] m_ctr [3];
    logic [2:0]    m_wrap;

    always #(CLK_P/2) clk = ~clk;

    perf_counter_bank #(.CNT_W(CW), .DATA_W(DW), .KEEP_HIGH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .rt_tick_i(tick), .retire_i(ret),
        .csr_addr_i(addr), .csr_rdata_o(rd_s), .csr_illegal_o(il_s), .lo_wrap_o(wr_s));
    perf_counter_bank #(.CNT_W(CW), .DATA_W(CW), .KEEP_HIGH(1'b1)) u_wide (
        .clk(clk), .rst_n(rst_n), .rt_tick_i(tick), .retire_i(ret),
        .csr_addr_i(addr), .csr_rdata_o(rd_w), .csr_illegal_o(il_w), .lo_wrap_o(wr_w));
    perf_counter_bank #(.CNT_W(CW), .DATA_W(DW), .KEEP_HIGH(1'b0)) u_lean (
        .clk(clk), .rst_n(rst_n), .rt_tick_i(tick), .retire_i(ret),
        .csr_addr_i(addr), .csr_rdata_o(rd_l), .csr_illegal_o(il_l), .lo_wrap_o(wr_l));

    // Model: counts and wrap pulses from the requirements.
    always @(posedge clk) begin
        logic [2:0] inc;
        inc = {ret, tick, 1'b1};
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_ctr[i] <= '0;
            m_wrap <= 3'b000;
        end else begin
            for (int i = 0; i < 3; i++) begin
                m_wrap[i] <= inc[i] && (m_ctr[i][CW/2-1:0] == '1);
                if (inc[i]) m_ctr[i] <= m_ctr[i] + 1'b1;
            end
        end
    end

    function automatic logic [CW-1:0] exp_rd(input logic [11:0] a, input bit wide, input bit keep);
        logic [CW-1:0] v;
        if (a >= 12'hC00 && a <= 12'hC02) begin
            v = m_ctr[a[1:0]];
            if (!keep) v = {{(CW/2){1'b0}}, v[CW/2-1:0]};
            return wide ? v : {{(CW-DW){1'b0}}, v[DW-1:0]};
        end
        if (!wide && a >= 12'hC80 && a <= 12'hC82) begin
            v = m_ctr[a[1:0]];
            if (!keep) v = '0;
            return {{(CW-DW){1'b0}}, v[CW-1 -: DW]};
        end
        return '0;
    endfunction

    function automatic bit exp_legal(input logic [11:0] a, input bit wide);
        return (a >= 12'hC00 && a <= 12'hC02) || (!wide && a >= 12'hC80 && a <= 12'hC82);
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
        end
    endtask

    task automatic check_all(input bit in_reset);
        logic [11:0] alist [12];
        string t;
        alist = '{12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82,
                  12'hC03, 12'hC83, 12'h000, 12'hC40, 12'hC7F, 12'hFFF};
        for (int k = 0; k < 12; k++) begin
            addr = alist[k];
            #1;
            if (in_reset) t = "R1";
            else if (k < 3) t = (k == 0) ? "R2/R5" : (k == 1) ? "R3/R5" : "R4/R5";
            else if (k < 6) t = "R6";
            else t = "R8";
            check(t, {{(CW-DW){1'b0}}, rd_s}, exp_rd(addr, 1'b0, 1'b1));
            check(in_reset ? "R1" : "R7", rd_w, exp_rd(addr, 1'b1, 1'b1));
            check(in_reset ? "R1" : "R10", {{(CW-DW){1'b0}}, rd_l}, exp_rd(addr, 1'b0, 1'b0));
            check("R8", {15'd0, il_s}, {15'd0, !exp_legal(addr, 1'b0)});
            check("R7/R8", {15'd0, il_w}, {15'd0, !exp_legal(addr, 1'b1)});
            check("R10/R8", {15'd0, il_l}, {15'd0, !exp_legal(addr, 1'b0)});
        end
        check(in_reset ? "R1" : "R9", {13'd0, wr_s}, {13'd0, m_wrap});
        check(in_reset ? "R1" : "R9", {13'd0, wr_w}, {13'd0, m_wrap});
        check(in_reset ? "R1" : "R10/R9", {13'd0, wr_l}, {13'd0, m_wrap});
    endtask

    task automatic run(input int cycles, input int mode);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check_all(1'b0);
            case (mode)
                0: begin tick = 1'b0; ret = 1'b0; end
                1: begin tick = 1'b1; ret = 1'b1; end
                default: begin tick = $urandom_range(0, 1); ret = $urandom_range(0, 1); end
            endcase
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(1'b1);
        rst_n = 1'b1;
        run(50, 0);
        run(600, 1);
        run(700, 2);
        // Mid-run reset with strobes still active.
        @(negedge clk);
        tick = 1'b1; ret = 1'b1; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all(1'b1);
        rst_n = 1'b1;
        run(300, 2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule